// File: doc/BRIEF.md
# Edge-Qualified Up/Down Counter

This block is a 16-bit up/down counter fed by five external pins: a count pin, a direction pin, a clear pin and two capture-trigger pins. Every pin passes through a synchronizer. An edge is found by comparing each synchronized sample with the one taken a cycle earlier. A single 8-bit configuration register decides which edges or levels matter on each pin. Some of its fields are honoured only in particular counter modes.

The counter has three counting modes and one stopped mode, selected by a 2-bit input. In mode A the count pin steps the counter and the direction pin level sets the direction. In mode B one pin counts up and the other counts down. In the quadrature mode the two pins are decoded as a two-phase encoder. The clear pin can clear the counter once on an edge, or hold it cleared while a level is present. It does this only in mode A. The two capture pins raise one-cycle event strobes. Whenever the run enable input is high, the configuration register is locked against writes.

Top module: `edge_udc_top`

## Requirements
- R1: After reset the configuration register reads 0x00, the counter is 0, and `cfg_err` and both capture strobes are low.
- R2: While `run_en` is low, a write replaces each configuration bit whose `cfg_wr_mask` bit is 1 with the matching `cfg_wr_data` bit. Bits whose mask bit is 0 keep their value. Field layout: [7:6] count edge, [5:4] clear behaviour, [3:2] capture 1 edge, [1:0] capture 0 edge.
- R3: A write while `run_en` is high leaves the register unchanged. It raises `cfg_err` for exactly the one cycle after the write.
- R4: Mode A is `mode`=00. A selected edge on the count pin adds 1 when the direction pin is high and subtracts 1 when it is low. The counter wraps modulo 2^16. The count edge field selects the edge: 00 falling, 01 rising, 11 both, 10 none.
- R5: Mode B is `mode`=01. A selected edge (same field) on the count pin adds 1, and a selected edge on the direction pin subtracts 1. When both occur in the same cycle, the counter does not change.
- R6: Quadrature mode is `mode`=10. Each change of exactly one of the count (A) and direction (B) pins steps the counter by one. The sequence AB=00,10,11,01 counts up and the reverse order counts down. The count edge field is ignored in this mode. `mode`=11 holds the counter.
- R7: In mode A, clear field 00 clears the counter on a falling edge of the clear pin and 01 clears it on a rising edge. The opposite edge has no effect.
- R8: In mode A, clear field 10 holds the counter at 0 while the clear pin is low, and 11 holds it at 0 while the pin is high. A clear overrides a count in the same cycle.
- R9: In modes B and quadrature, the clear field and the clear pin have no effect.
- R10: While `run_en` is high, each capture pin produces a one-cycle strobe on its `cap_evt` bit for the edges its field selects: 00 none, 01 rising, 10 falling, 11 both. While `run_en` is low, no strobe is produced.
- R11: While `run_en` is low, the counter holds its value whatever the pins do.
- R12: With the default two synchronizer stages, a pin change made before a rising clock edge shows in `count` or `cap_evt` right after the third rising edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter enable; also locks the configuration register |
| mode | input | 2 | 00 mode A, 01 mode B, 10 quadrature, 11 stopped |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_wr_mask | input | 8 | Per-bit write enable |
| pin_cnt | input | 1 | Count pin (phase A in quadrature) |
| pin_dir | input | 1 | Direction pin (phase B in quadrature, down pin in mode B) |
| pin_clr | input | 1 | Clear pin |
| pin_cap | input | 2 | Capture trigger pins |
| cfg_q | output | 8 | Current configuration register |
| cfg_err | output | 1 | One-cycle flag for a rejected write |
| count | output | 16 | Counter value |
| cap_evt | output | 2 | Capture event strobes |

## Verification
The assertions assume that every pin is low while reset is applied, so the first synchronized samples do not produce a false edge. They also assume that `mode` and the configuration do not change while the counter runs. The bench lowers `run_en` before every reconfiguration or mode change. It holds each pin level for at least four cycles, so every edge is seen once and each step is checked after the pipeline has settled. Both pins of a quadrature pair never change in the same step.

// File: rtl/edge_udc_pkg.sv
package edge_udc_pkg;

    localparam int CFG_W = 8;
    localparam int N_CAP = 2;

    typedef enum logic [1:0] {
        MODE_A    = 2'b00,
        MODE_B    = 2'b01,
        MODE_QUAD = 2'b10,
        MODE_STOP = 2'b11
    } udc_mode_e;

    typedef struct packed {
        logic [1:0]            cnt_edge;
        logic [1:0]            clr_sel;
        logic [N_CAP-1:0][1:0] cap_edge;
    } udc_cfg_t;

    // count/direction field: 00 fall, 01 rise, 11 both, 10 none
    function automatic logic cnt_edge_hit(input logic [1:0] sel, input logic lvl, input logic prev);
        logic rise;
        logic fall;
        rise = lvl & ~prev;
        fall = ~lvl & prev;
        unique case (sel)
            2'b00:   cnt_edge_hit = fall;
            2'b01:   cnt_edge_hit = rise;
            2'b11:   cnt_edge_hit = rise | fall;
            default: cnt_edge_hit = 1'b0;
        endcase
    endfunction

    // capture field: 00 none, 01 rise, 10 fall, 11 both
    function automatic logic cap_edge_hit(input logic [1:0] sel, input logic lvl, input logic prev);
        cap_edge_hit = (sel[0] & lvl & ~prev) | (sel[1] & ~lvl & prev);
    endfunction

endpackage

// File: rtl/udc_pin_sync.sv
module udc_pin_sync #(
    parameter int N_PINS = 5,
    parameter int STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] lvl_o,
    output logic [N_PINS-1:0] prev_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][N_PINS-1:0] pipe;
        logic [N_PINS-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.prev = st_q.pipe[LAST];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o  = st_q.pipe[LAST];
    assign prev_o = st_q.prev;

endmodule

// File: rtl/udc_cfg_reg.sv
module udc_cfg_reg
    import edge_udc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lock_i,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic [CFG_W-1:0] wr_mask_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             err_o
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = wr_en_i & lock_i;
        if (wr_en_i && !lock_i) begin
            st_d.cfg = (st_q.cfg & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign err_o = st_q.err;

    AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_i |=> $stable(cfg_o)); // R3
    AST_LOCK_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && lock_i) |=> err_o); // R3
    AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && lock_i) |=> !err_o); // R3
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(cfg_o)); // R2

endmodule

// File: rtl/udc_cap_chan.sv
module udc_cap_chan
    import edge_udc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_en_i,
    input  logic [1:0] sel_i,
    input  logic       lvl_i,
    input  logic       prev_i,
    output logic       evt_o
);
    typedef struct packed {
        logic evt;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = run_en_i & cap_edge_hit(sel_i, lvl_i, prev_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign evt_o = st_q.evt;

    AST_CAP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_en_i |=> !evt_o); // R10
    AST_CAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_i == prev_i) |=> !evt_o); // R10

endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
    import edge_udc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_en_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       cnt_edge_i,
    input  logic [1:0]       clr_sel_i,
    input  logic             cnt_lvl_i,
    input  logic             cnt_prev_i,
    input  logic             dir_lvl_i,
    input  logic             dir_prev_i,
    input  logic             clr_lvl_i,
    input  logic             clr_prev_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t  st_d, st_q;
    udc_mode_e mode;
    logic      inc, dec, clr;
    logic      up_hit, dn_hit, a_chg, b_chg, b_old;

    assign mode = udc_mode_e'(mode_i);

    always_comb begin
        inc    = 1'b0;
        dec    = 1'b0;
        clr    = 1'b0;
        up_hit = cnt_edge_hit(cnt_edge_i, cnt_lvl_i, cnt_prev_i);
        dn_hit = cnt_edge_hit(cnt_edge_i, dir_lvl_i, dir_prev_i);
        a_chg  = cnt_lvl_i ^ cnt_prev_i;
        b_chg  = dir_lvl_i ^ dir_prev_i;
        b_old  = dir_prev_i;
        unique case (mode)
            MODE_A: begin
                inc = up_hit & dir_lvl_i;
                dec = up_hit & ~dir_lvl_i;
                unique case (clr_sel_i)
                    2'b00:   clr = ~clr_lvl_i & clr_prev_i;
                    2'b01:   clr = clr_lvl_i & ~clr_prev_i;
                    2'b10:   clr = ~clr_lvl_i;
                    default: clr = clr_lvl_i;
                endcase
            end
            MODE_B: begin
                inc = up_hit & ~dn_hit;
                dec = dn_hit & ~up_hit;
            end
            MODE_QUAD: begin
                if (a_chg ^ b_chg) begin
                    inc = cnt_lvl_i ^ b_old;
                    dec = ~(cnt_lvl_i ^ b_old);
                end
            end
            default: ;
        endcase
        if (!run_en_i) begin
            inc = 1'b0;
            dec = 1'b0;
            clr = 1'b0;
        end

        st_d = st_q;
        if (clr)      st_d.cnt = '0;
        else if (inc) st_d.cnt = st_q.cnt + ONE;
        else if (dec) st_d.cnt = st_q.cnt - ONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_en_i |=> $stable(count_o)); // R11
    AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_en_i |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + ONE) ||
                      (count_o == $past(count_o) - ONE) || (count_o == '0))); // R4
    AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en_i && mode_i == 2'b00 && clr_sel_i[1] && (clr_lvl_i == clr_sel_i[0]))
        |=> (count_o == '0)); // R8
    AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b11) |=> $stable(count_o)); // R6

endmodule

// File: rtl/edge_udc_top.sv
module edge_udc_top
    import edge_udc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [1:0]       mode,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    input  logic [CFG_W-1:0] cfg_wr_mask,
    input  logic             pin_cnt,
    input  logic             pin_dir,
    input  logic             pin_clr,
    input  logic [N_CAP-1:0] pin_cap,
    output logic [CFG_W-1:0] cfg_q,
    output logic             cfg_err,
    output logic [CNT_W-1:0] count,
    output logic [N_CAP-1:0] cap_evt
);
    localparam int N_PINS  = 3 + N_CAP;
    localparam int IDX_CNT = 0;
    localparam int IDX_DIR = 1;
    localparam int IDX_CLR = 2;
    localparam int IDX_CAP = 3;

    logic [N_PINS-1:0] pins, lvl, prev;
    udc_cfg_t          cfg;

    assign pins = {pin_cap, pin_clr, pin_dir, pin_cnt};
    assign cfg  = udc_cfg_t'(cfg_q);

    udc_pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk),
        .rst_ni(rst_n),
        .pin_i (pins),
        .lvl_o (lvl),
        .prev_o(prev)
    );

    udc_cfg_reg u_cfg (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .lock_i   (run_en),
        .wr_en_i  (cfg_wr_en),
        .wr_data_i(cfg_wr_data),
        .wr_mask_i(cfg_wr_mask),
        .cfg_o    (cfg_q),
        .err_o    (cfg_err)
    );

    udc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .run_en_i  (run_en),
        .mode_i    (mode),
        .cnt_edge_i(cfg.cnt_edge),
        .clr_sel_i (cfg.clr_sel),
        .cnt_lvl_i (lvl[IDX_CNT]),
        .cnt_prev_i(prev[IDX_CNT]),
        .dir_lvl_i (lvl[IDX_DIR]),
        .dir_prev_i(prev[IDX_DIR]),
        .clr_lvl_i (lvl[IDX_CLR]),
        .clr_prev_i(prev[IDX_CLR]),
        .count_o   (count)
    );

    for (genvar c = 0; c < N_CAP; c++) begin : g_cap
        udc_cap_chan u_chan (
            .clk_i   (clk),
            .rst_ni  (rst_n),
            .run_en_i(run_en),
            .sel_i   (cfg.cap_edge[c]),
            .lvl_i   (lvl[IDX_CAP+c]),
            .prev_i  (prev[IDX_CAP+c]),
            .evt_o   (cap_evt[c])
        );
    end

endmodule

// File: tb/edge_udc_top_tb.sv
module edge_udc_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_wr_mask = '0;
    logic        pin_cnt = 1'b0;
    logic        pin_dir = 1'b0;
    logic        pin_clr = 1'b0;
    logic [1:0]  pin_cap = '0;
    logic [7:0]  cfg_q;
    logic        cfg_err;
    logic [15:0] count;
    logic [1:0]  cap_evt;

    int n_chk = 0;
    int n_bad = 0;
    int mcnt  = 0;
    logic [7:0] mcfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_udc_top u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_wr_mask(cfg_wr_mask),
        .pin_cnt(pin_cnt), .pin_dir(pin_dir), .pin_clr(pin_clr), .pin_cap(pin_cap),
        .cfg_q(cfg_q), .cfg_err(cfg_err), .count(count), .cap_evt(cap_evt)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wcfg(input logic [7:0] d, input logic [7:0] m);
        cfg_wr_en = 1'b1; cfg_wr_data = d; cfg_wr_mask = m;
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic clr_cnt();
        run_en = 1'b0; mode = 2'b00; pin_clr = 1'b0;
        wcfg(8'b00_10_0000, 8'hFF);
        tick(4);
        run_en = 1'b1;
        tick(2);
        run_en = 1'b0;
        mcnt = 0;
    endtask

    task automatic pulse_cnt();
        pin_cnt = 1'b1; tick(4);
        pin_cnt = 1'b0; tick(4);
    endtask

    function automatic bit sel_hit(input logic [1:0] e, input bit rise);
        case (e)
            2'b00:   return !rise;
            2'b01:   return rise;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 cfg", {24'd0, cfg_q}, 32'h00);
        chk("R1 count", {16'd0, count}, 32'h0);
        chk("R1 err/evt", {29'd0, cfg_err, cap_evt}, 32'h0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 cfg after release", {24'd0, cfg_q}, 32'h00);

        // R2 masked writes
        wcfg(8'hA5, 8'hFF); mcfg = 8'hA5;
        chk("R2 full", {24'd0, cfg_q}, {24'd0, mcfg});
        wcfg(8'h00, 8'h0F); mcfg = mcfg & 8'hF0;
        chk("R2 low nibble", {24'd0, cfg_q}, {24'd0, mcfg});
        for (int b = 0; b < 8; b++) begin
            logic [7:0] m;
            m = 8'h01 << b;
            wcfg(~mcfg, m);
            mcfg = (mcfg & ~m) | (~mcfg & m);
            chk("R2 single bit", {24'd0, cfg_q}, {24'd0, mcfg});
        end

        // R3 locked write
        run_en = 1'b1;
        cfg_wr_en = 1'b1; cfg_wr_data = ~mcfg; cfg_wr_mask = 8'hFF;
        tick(1);
        cfg_wr_en = 1'b0;
        chk("R3 cfg kept", {24'd0, cfg_q}, {24'd0, mcfg});
        chk("R3 err set", {31'd0, cfg_err}, 32'd1);
        tick(1);
        chk("R3 err one cycle", {31'd0, cfg_err}, 32'd0);
        run_en = 1'b0;

        // R4 sweep of edge field and direction in mode A
        for (int e = 0; e < 4; e++) begin
            for (int dr = 0; dr < 2; dr++) begin
                clr_cnt();
                wcfg({e[1:0], 2'b11, 4'h0}, 8'hFF);
                pin_dir = dr[0];
                tick(4);
                run_en = 1'b1;
                for (int k = 0; k < 6; k++) begin
                    logic v;
                    v = ~pin_cnt;
                    if (sel_hit(e[1:0], v)) mcnt = mcnt + (dr == 1 ? 1 : -1);
                    pin_cnt = v;
                    tick(4);
                end
                chk("R4 mode A count", {16'd0, count}, mcnt & 32'hFFFF);
                run_en = 1'b0;
            end
        end

        // R12 latency
        clr_cnt();
        wcfg(8'b01_11_0000, 8'hFF);
        pin_dir = 1'b1;
        tick(4);
        run_en = 1'b1;
        pin_cnt = 1'b1;
        tick(1); chk("R12 edge1", {16'd0, count}, 32'd0);
        tick(1); chk("R12 edge2", {16'd0, count}, 32'd0);
        tick(1); chk("R12 edge3", {16'd0, count}, 32'd1);
        pin_cnt = 1'b0; tick(4);

        // R11 hold while disabled
        run_en = 1'b0;
        pulse_cnt(); pulse_cnt();
        chk("R11 hold", {16'd0, count}, 32'd1);

        // R7 clear on falling edge, then rising edge
        clr_cnt();
        wcfg(8'b01_00_0000, 8'hFF);
        pin_dir = 1'b1; tick(4);
        run_en = 1'b1;
        pulse_cnt(); pulse_cnt(); pulse_cnt();
        chk("R7 counted", {16'd0, count}, 32'd3);
        pin_clr = 1'b1; tick(4);
        chk("R7 rise ignored", {16'd0, count}, 32'd3);
        pin_clr = 1'b0; tick(4);
        chk("R7 fall clears", {16'd0, count}, 32'd0);
        run_en = 1'b0;
        wcfg(8'b01_01_0000, 8'hFF);
        run_en = 1'b1;
        pulse_cnt(); pulse_cnt();
        pin_clr = 1'b1; tick(4);
        chk("R7 rise clears", {16'd0, count}, 32'd0);
        pulse_cnt();
        pin_clr = 1'b0; tick(4);
        chk("R7 fall ignored", {16'd0, count}, 32'd1);

        // R8 level hold
        run_en = 1'b0;
        wcfg(8'b01_11_0000, 8'hFF);
        pin_clr = 1'b1; tick(4);
        run_en = 1'b1;
        pulse_cnt(); pulse_cnt();
        chk("R8 high hold beats count", {16'd0, count}, 32'd0);
        pin_clr = 1'b0; tick(4);
        pulse_cnt();
        chk("R8 released", {16'd0, count}, 32'd1);
        run_en = 1'b0;
        wcfg(8'b01_10_0000, 8'hFF);
        run_en = 1'b1; tick(4);
        chk("R8 low hold", {16'd0, count}, 32'd0);
        pulse_cnt();
        chk("R8 low hold beats count", {16'd0, count}, 32'd0);
        run_en = 1'b0;

        // R5 mode B, R9 clear ignored
        clr_cnt();
        wcfg(8'b01_11_0000, 8'hFF);
        mode = 2'b01; pin_dir = 1'b0; pin_clr = 1'b1; tick(4);
        run_en = 1'b1;
        pulse_cnt(); pulse_cnt(); pulse_cnt();
        chk("R5 up pin", {16'd0, count}, 32'd3);
        pin_dir = 1'b1; tick(4); pin_dir = 1'b0; tick(4);
        chk("R5 down pin", {16'd0, count}, 32'd2);
        pin_cnt = 1'b1; pin_dir = 1'b1; tick(4);
        pin_cnt = 1'b0; pin_dir = 1'b0; tick(4);
        chk("R5 simultaneous", {16'd0, count}, 32'd2);
        chk("R9 level clear ignored in B", {16'd0, count}, 32'd2);
        pin_clr = 1'b0; tick(4);
        pin_clr = 1'b1; tick(4);
        pulse_cnt();
        chk("R9 edges ignored in B", {16'd0, count}, 32'd3);
        run_en = 1'b0; pin_clr = 1'b0;

        // R6 quadrature
        clr_cnt();
        wcfg(8'b10_11_0000, 8'hFF);
        mode = 2'b10; pin_cnt = 1'b0; pin_dir = 1'b0; tick(4);
        run_en = 1'b1;
        for (int s = 0; s < 8; s++) begin
            logic [1:0] fw;
            case (s % 4)
                0: fw = 2'b10; 1: fw = 2'b11; 2: fw = 2'b01; default: fw = 2'b00;
            endcase
            pin_cnt = fw[1]; pin_dir = fw[0]; tick(4);
        end
        chk("R6 forward", {16'd0, count}, 32'd8);
        for (int s = 0; s < 4; s++) begin
            logic [1:0] rv;
            case (s)
                0: rv = 2'b01; 1: rv = 2'b11; 2: rv = 2'b10; default: rv = 2'b00;
            endcase
            pin_cnt = rv[1]; pin_dir = rv[0]; tick(4);
        end
        chk("R6 reverse", {16'd0, count}, 32'd4);
        pin_clr = 1'b1; tick(4);
        chk("R9 clear ignored in quad", {16'd0, count}, 32'd4);
        pin_clr = 1'b0; tick(4);
        run_en = 1'b0; mode = 2'b11; tick(1); run_en = 1'b1;
        pulse_cnt(); pulse_cnt();
        chk("R6 stopped mode", {16'd0, count}, 32'd4);
        run_en = 1'b0;

        // R10 capture sweep
        for (int ch = 0; ch < 2; ch++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int r = 0; r < 2; r++) begin
                    int seen, other, expn;
                    logic [7:0] d;
                    d = '0;
                    if (ch == 0) d[1:0] = sel[1:0]; else d[3:2] = sel[1:0];
                    run_en = 1'b0;
                    wcfg(d, 8'hFF);
                    run_en = r[0];
                    seen = 0; other = 0;
                    for (int ph = 0; ph < 2; ph++) begin
                        pin_cap[ch] = (ph == 0);
                        for (int t = 0; t < 5; t++) begin
                            tick(1);
                            seen  += cap_evt[ch];
                            other += cap_evt[1-ch];
                        end
                    end
                    expn = (r == 0) ? 0 : (sel == 3 ? 2 : (sel == 0 ? 0 : 1));
                    chk("R10 strobes", seen, expn);
                    chk("R10 other channel quiet", other, 0);
                end
            end
        end
        run_en = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule